// File: doc/BRIEF.md
# Root Port Error Message Collector

This block sits at the receiving end of a root port and collects error messages sent up by devices below it. Each message arrives on a valid/ready stream and carries a 16-bit requester identity and a two-bit severity (correctable, non-fatal or fatal). The block keeps a root error status word that records:

- first receipt of each class;
- repeated receipt of each class;
- whether a fatal error was the first uncorrectable one.

It also latches the identity of the first correctable sender and of the first uncorrectable sender.

A three-bit enable word selects which received severities may interrupt. The interrupt is delivered in one of two ways, chosen by `msi_mode`:

- **Level mode:** a level line that mirrors the enabled condition.
- **Message mode:** a one-cycle pulse, issued only when the enabled condition turns from false to true. The pulse is accompanied by a vector number that is loaded through a separate input and is read-only otherwise.

Status bits are cleared by write-1-to-clear. The message stream never applies back-pressure once reset has been released. `msg_ready` is low during reset and rises at the first clock edge after reset, and a message is taken on every edge where `msg_valid` and `msg_ready` are both high.

Top module: `rp_errcol`

## Requirements
- R1: After reset, `root_sts`, `root_cmd`, `int_vector`, both source ID outputs, `irq_level` and `irq_msg` are all zero. `msg_ready` is high from the first clock edge after reset release.
- R2: For a correctable message (severity code 0), the block first looks at status bit 0 (correctable received).
  - If bit 0 is already set, it sets bit 1 (multiple correctable) and keeps `cor_src_id`.
  - If bit 0 is clear, it loads `cor_src_id` with the message source.
  - In either case, bit 0 is set afterwards.
- R3: A non-fatal message (severity code 1) sets status bit 5.
- R4: A fatal message (severity code 2) sets status bit 6. It also sets status bit 4 (first fatal), but only if status bit 2 (uncorrectable received) was clear before that message.
- R5: For a non-fatal or fatal message, the block first looks at status bit 2.
  - If bit 2 is already set, it sets bit 3 (multiple uncorrectable) and keeps `unc_src_id`.
  - If bit 2 is clear, it loads `unc_src_id` with the message source.
  - In either case, bit 2 is set afterwards.
- R6: A message with severity code 3 is accepted and changes neither the status word nor the source IDs.
- R7: While `sts_clr_we` is high, every status bit whose `sts_clr_mask` bit is 1 is cleared. A message taken in the same cycle is evaluated against the already-cleared status, and the bits that the message sets remain set.
- R8: When `msi_mode` is 0, `irq_level` is high exactly when at least one of these holds:
  - `root_cmd` bit 0 is set and status bit 0 is set;
  - `root_cmd` bit 1 is set and status bit 5 is set;
  - `root_cmd` bit 2 is set and status bit 6 is set.

  `irq_level` therefore follows command writes, messages and clears. When `msi_mode` is 1, `irq_level` is low.
- R9: When `msi_mode` is 1, `irq_msg` pulses for exactly one cycle after any edge at which the enabled condition of R8 goes from false to true. The cause may be a message or a command write. No pulse is issued while the condition stays true.
- R10: `cmd_we` loads `root_cmd` from `cmd_wdata`. `vec_we` loads `int_vector` from `vec_wdata`. `int_vector` changes in no other way.
- R11: The stream never stalls: `msg_ready` stays high after reset, and a message is taken in every cycle where `msg_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| msg_valid | input | 1 | Error message present |
| msg_ready | output | 1 | Block can take a message |
| msg_sev | input | 2 | Severity: 0 correctable, 1 non-fatal, 2 fatal, 3 none |
| msg_src | input | SRC_W | Source identity of the message |
| msi_mode | input | 1 | 1 selects message interrupts, 0 selects the level line |
| cmd_we | input | 1 | Write strobe for the enable word |
| cmd_wdata | input | 3 | Enables: bit 0 correctable, bit 1 non-fatal, bit 2 fatal |
| sts_clr_we | input | 1 | Write strobe for status clearing |
| sts_clr_mask | input | 7 | Write-1-to-clear mask for the status word |
| vec_we | input | 1 | Load strobe for the interrupt vector |
| vec_wdata | input | VEC_W | New interrupt vector |
| root_cmd | output | 3 | Enable word |
| root_sts | output | 7 | Status word (bit layout in R2 to R5) |
| cor_src_id | output | SRC_W | First correctable source |
| unc_src_id | output | SRC_W | First uncorrectable source |
| int_vector | output | VEC_W | Vector carried with message interrupts |
| irq_level | output | 1 | Level interrupt |
| irq_msg | output | 1 | One-cycle message interrupt pulse |

## Verification
The inputs for an edge are registered at that edge. Status, source IDs, enables, vector and the level line all show their new values in the cycle right after it, and `irq_msg` is high for that same following cycle only. The bench updates its behavioural model at each rising edge and compares every output at the next falling edge, so every result is checked in the cycle it is due. Directed sequences cover first and repeated receipt, first-fatal ordering, clears that collide with messages, and rising versus already-true conditions in message mode. A long random run then mixes all inputs.

// File: rtl/rp_errcol_pkg.sv
package rp_errcol_pkg;
  localparam int STS_W = 7;
  localparam int SEV_N = 3;

  // status bit positions
  localparam int B_COR_RCV   = 0;
  localparam int B_COR_MULTI = 1;
  localparam int B_UNC_RCV   = 2;
  localparam int B_UNC_MULTI = 3;
  localparam int B_FAT_FIRST = 4;
  localparam int B_NF_RCV    = 5;
  localparam int B_FAT_RCV   = 6;

  typedef enum logic [1:0] {
    SEV_COR   = 2'd0,
    SEV_NF    = 2'd1,
    SEV_FATAL = 2'd2,
    SEV_NONE  = 2'd3
  } sev_e;

  // status bit recording receipt of severity s (enable bit s)
  function automatic int rcv_pos(int s);
    case (s)
      0:       return B_COR_RCV;
      1:       return B_NF_RCV;
      default: return B_FAT_RCV;
    endcase
  endfunction
endpackage

// File: rtl/rp_errcol_accept.sv
module rp_errcol_accept (
  input  logic clk,
  input  logic rst_n,
  input  logic msg_valid,
  output logic msg_ready,
  output logic msg_take
);
  logic ready_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ready_q <= 1'b0;
    else        ready_q <= 1'b1;
  end

  assign msg_ready = ready_q;
  assign msg_take  = msg_valid && ready_q;

  // R11
  no_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready_q |=> ready_q);
endmodule

// File: rtl/rp_errcol_status.sv
module rp_errcol_status
  import rp_errcol_pkg::*;
#(
  parameter int SRC_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [1:0]        sev,
  input  logic [SRC_W-1:0]  src,
  input  logic [STS_W-1:0]  clr,
  output logic [STS_W-1:0]  sts_q,
  output logic [SRC_W-1:0]  cor_src_q,
  output logic [SRC_W-1:0]  unc_src_q,
  output logic [SEV_N-1:0]  rcv_q,
  output logic [SEV_N-1:0]  rcv_nxt
);
  logic [STS_W-1:0] base, sts_nxt;
  logic [SRC_W-1:0] cor_nxt, unc_nxt;
  logic             is_unc;

  assign is_unc = (sev == SEV_NF) || (sev == SEV_FATAL);

  always_comb begin
    base    = sts_q & ~clr;
    sts_nxt = base;
    cor_nxt = cor_src_q;
    unc_nxt = unc_src_q;
    if (take) begin
      case (sev_e'(sev))
        SEV_COR: begin
          if (base[B_COR_RCV]) sts_nxt[B_COR_MULTI] = 1'b1;
          else                 cor_nxt = src;
          sts_nxt[B_COR_RCV] = 1'b1;
        end
        SEV_NF: sts_nxt[B_NF_RCV] = 1'b1;
        SEV_FATAL: begin
          if (!base[B_UNC_RCV]) sts_nxt[B_FAT_FIRST] = 1'b1;
          sts_nxt[B_FAT_RCV] = 1'b1;
        end
        default: ;
      endcase
      if (is_unc) begin
        if (base[B_UNC_RCV]) sts_nxt[B_UNC_MULTI] = 1'b1;
        else                 unc_nxt = src;
        sts_nxt[B_UNC_RCV] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_q     <= '0;
      cor_src_q <= '0;
      unc_src_q <= '0;
    end else begin
      sts_q     <= sts_nxt;
      cor_src_q <= cor_nxt;
      unc_src_q <= unc_nxt;
    end
  end

  for (genvar g = 0; g < SEV_N; g++) begin : g_rcv
    assign rcv_q[g]   = sts_q[rcv_pos(g)];
    assign rcv_nxt[g] = sts_nxt[rcv_pos(g)];
  end

  // R2
  multi_cor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && sev == 2'd0 && sts_q[B_COR_RCV] && !clr[B_COR_RCV])
      |=> (sts_q[B_COR_MULTI] && $stable(cor_src_q)));

  // R4
  first_fatal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && sev == 2'd2 && !sts_q[B_UNC_RCV]) |=> sts_q[B_FAT_FIRST]);

  // R5
  unc_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && (sev == 2'd1 || sev == 2'd2) && !(sts_q[B_UNC_RCV] && !clr[B_UNC_RCV]))
      |=> (unc_src_q == $past(src)));

  // R6
  no_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && sev == 2'd3 && clr == '0)
      |=> ($stable(sts_q) && $stable(cor_src_q) && $stable(unc_src_q)));
endmodule

// File: rtl/rp_errcol_irq.sv
module rp_errcol_irq
  import rp_errcol_pkg::*;
#(
  parameter int VEC_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             msi_mode,
  input  logic             cmd_we,
  input  logic [SEV_N-1:0] cmd_wdata,
  input  logic             vec_we,
  input  logic [VEC_W-1:0] vec_wdata,
  input  logic [SEV_N-1:0] rcv_q,
  input  logic [SEV_N-1:0] rcv_nxt,
  output logic [SEV_N-1:0] cmd_q,
  output logic [VEC_W-1:0] vec_q,
  output logic             irq_level,
  output logic             irq_pulse
);
  logic [SEV_N-1:0] cmd_nxt;
  logic             cond, cond_nxt;

  assign cmd_nxt  = cmd_we ? cmd_wdata : cmd_q;
  assign cond     = |(cmd_q & rcv_q);
  assign cond_nxt = |(cmd_nxt & rcv_nxt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q     <= '0;
      vec_q     <= '0;
      irq_pulse <= 1'b0;
    end else begin
      cmd_q     <= cmd_nxt;
      if (vec_we) vec_q <= vec_wdata;
      irq_pulse <= msi_mode && !cond && cond_nxt;
    end
  end

  assign irq_level = !msi_mode && cond;

  // R9
  pulse_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> (cond && !$past(cond)));

  // R9
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |=> !irq_pulse);

  // R10
  vec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !vec_we |=> $stable(vec_q));
endmodule

// File: rtl/rp_errcol.sv
module rp_errcol
  import rp_errcol_pkg::*;
#(
  parameter int SRC_W = 16,
  parameter int VEC_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             msg_valid,
  output logic             msg_ready,
  input  logic [1:0]       msg_sev,
  input  logic [SRC_W-1:0] msg_src,
  input  logic             msi_mode,
  input  logic             cmd_we,
  input  logic [2:0]       cmd_wdata,
  input  logic             sts_clr_we,
  input  logic [6:0]       sts_clr_mask,
  input  logic             vec_we,
  input  logic [VEC_W-1:0] vec_wdata,
  output logic [2:0]       root_cmd,
  output logic [6:0]       root_sts,
  output logic [SRC_W-1:0] cor_src_id,
  output logic [SRC_W-1:0] unc_src_id,
  output logic [VEC_W-1:0] int_vector,
  output logic             irq_level,
  output logic             irq_msg
);
  logic             take;
  logic [STS_W-1:0] clr;
  logic [SEV_N-1:0] rcv_q, rcv_nxt;

  assign clr = sts_clr_we ? sts_clr_mask : '0;

  rp_errcol_accept u_accept (
    .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid),
    .msg_ready(msg_ready), .msg_take(take)
  );

  rp_errcol_status #(.SRC_W(SRC_W)) u_status (
    .clk(clk), .rst_n(rst_n), .take(take), .sev(msg_sev), .src(msg_src),
    .clr(clr), .sts_q(root_sts), .cor_src_q(cor_src_id),
    .unc_src_q(unc_src_id), .rcv_q(rcv_q), .rcv_nxt(rcv_nxt)
  );

  rp_errcol_irq #(.VEC_W(VEC_W)) u_irq (
    .clk(clk), .rst_n(rst_n), .msi_mode(msi_mode), .cmd_we(cmd_we),
    .cmd_wdata(cmd_wdata), .vec_we(vec_we), .vec_wdata(vec_wdata),
    .rcv_q(rcv_q), .rcv_nxt(rcv_nxt), .cmd_q(root_cmd), .vec_q(int_vector),
    .irq_level(irq_level), .irq_pulse(irq_msg)
  );

  // R7
  clr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_clr_we && sts_clr_mask[0] && !(take && msg_sev == 2'd0)) |=> !root_sts[0]);
endmodule

// File: tb/rp_errcol_tb_top.sv
`timescale 1ns/1ps
module rp_errcol_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        msg_valid = 0, msi_mode = 0, cmd_we = 0, sts_clr_we = 0, vec_we = 0;
  logic [1:0]  msg_sev = 0;
  logic [15:0] msg_src = 0;
  logic [2:0]  cmd_wdata = 0;
  logic [6:0]  sts_clr_mask = 0;
  logic [4:0]  vec_wdata = 0;
  logic        msg_ready, irq_level, irq_msg;
  logic [2:0]  root_cmd;
  logic [6:0]  root_sts;
  logic [15:0] cor_src_id, unc_src_id;
  logic [4:0]  int_vector;

  rp_errcol dut_i (
    .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_ready(msg_ready),
    .msg_sev(msg_sev), .msg_src(msg_src), .msi_mode(msi_mode),
    .cmd_we(cmd_we), .cmd_wdata(cmd_wdata), .sts_clr_we(sts_clr_we),
    .sts_clr_mask(sts_clr_mask), .vec_we(vec_we), .vec_wdata(vec_wdata),
    .root_cmd(root_cmd), .root_sts(root_sts), .cor_src_id(cor_src_id),
    .unc_src_id(unc_src_id), .int_vector(int_vector),
    .irq_level(irq_level), .irq_msg(irq_msg)
  );

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  // behavioural reference state
  bit        m_ready, m_pulse;
  bit        cor_rcv, cor_multi, unc_rcv, unc_multi, fat_first, nf_rcv, fat_rcv;
  bit [2:0]  m_cmd;
  bit [4:0]  m_vec;
  bit [15:0] m_cor_src, m_unc_src;

  function automatic bit m_cond();
    return (m_cmd[0] && cor_rcv) || (m_cmd[1] && nf_rcv) || (m_cmd[2] && fat_rcv);
  endfunction

  function automatic bit [6:0] m_sts();
    return {fat_rcv, nf_rcv, fat_first, unc_multi, unc_rcv, cor_multi, cor_rcv};
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ready = 0; m_pulse = 0; m_cmd = 0; m_vec = 0; m_cor_src = 0; m_unc_src = 0;
      {fat_rcv, nf_rcv, fat_first, unc_multi, unc_rcv, cor_multi, cor_rcv} = '0;
    end else begin
      bit prev;
      prev = m_cond();
      if (sts_clr_we) begin
        if (sts_clr_mask[0]) cor_rcv = 0;
        if (sts_clr_mask[1]) cor_multi = 0;
        if (sts_clr_mask[2]) unc_rcv = 0;
        if (sts_clr_mask[3]) unc_multi = 0;
        if (sts_clr_mask[4]) fat_first = 0;
        if (sts_clr_mask[5]) nf_rcv = 0;
        if (sts_clr_mask[6]) fat_rcv = 0;
      end
      if (msg_valid && m_ready) begin
        if (msg_sev == 0) begin
          if (cor_rcv) cor_multi = 1; else m_cor_src = msg_src;
          cor_rcv = 1;
        end
        if (msg_sev == 1) nf_rcv = 1;
        if (msg_sev == 2) begin
          if (!unc_rcv) fat_first = 1;
          fat_rcv = 1;
        end
        if (msg_sev == 1 || msg_sev == 2) begin
          if (unc_rcv) unc_multi = 1; else m_unc_src = msg_src;
          unc_rcv = 1;
        end
      end
      if (cmd_we) m_cmd = cmd_wdata;
      if (vec_we) m_vec = vec_wdata;
      m_pulse = msi_mode && !prev && m_cond();
      m_ready = 1;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R2 R3 R4 R5 R6 R7 status", 32'(root_sts), 32'(m_sts()));
      chk("R2 cor_src_id", 32'(cor_src_id), 32'(m_cor_src));
      chk("R5 unc_src_id", 32'(unc_src_id), 32'(m_unc_src));
      chk("R8 irq_level", 32'(irq_level), 32'(!msi_mode && m_cond()));
      chk("R9 irq_msg", 32'(irq_msg), 32'(m_pulse));
      chk("R10 root_cmd", 32'(root_cmd), 32'(m_cmd));
      chk("R10 int_vector", 32'(int_vector), 32'(m_vec));
      chk("R11 msg_ready", 32'(msg_ready), 32'(m_ready));
    end
  end

  task automatic idle();
    msg_valid = 0; cmd_we = 0; sts_clr_we = 0; vec_we = 0;
  endtask

  task automatic step();
    @(posedge clk); #1; idle();
  endtask

  task automatic send(logic [1:0] s, logic [15:0] id);
    msg_valid = 1; msg_sev = s; msg_src = id; step();
  endtask

  task automatic wcmd(logic [2:0] c);
    cmd_we = 1; cmd_wdata = c; step();
  endtask

  task automatic wclr(logic [6:0] m);
    sts_clr_we = 1; sts_clr_mask = m; step();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    step();
    @(negedge clk);
    // R1 explicit reset state
    chk("R1 status", 32'(root_sts), 0);
    chk("R1 cmd", 32'(root_cmd), 0);
    chk("R1 vector", 32'(int_vector), 0);
    chk("R1 irq", 32'({irq_level, irq_msg}), 0);
    chk("R1 ready", 32'(msg_ready), 1);
    #1;
    // level mode, R2..R6
    msi_mode = 0;
    wcmd(3'b111);
    send(0, 16'hA001);
    send(0, 16'hA002);
    send(2, 16'hB001);
    send(1, 16'hB002);
    send(3, 16'hC000);
    wcmd(3'b000);
    wcmd(3'b100);
    wclr(7'h7F);
    // non-fatal first, then fatal: no first-fatal
    send(1, 16'hD001);
    send(2, 16'hD002);
    // R7 clear colliding with a message
    sts_clr_we = 1; sts_clr_mask = 7'h7F; msg_valid = 1; msg_sev = 0; msg_src = 16'hE001; step();
    sts_clr_we = 1; sts_clr_mask = 7'h04; msg_valid = 1; msg_sev = 2; msg_src = 16'hE002; step();
    wclr(7'h7F);
    // message mode, R9 / R10
    msi_mode = 1;
    vec_we = 1; vec_wdata = 5'd17; step();
    wcmd(3'b001);
    send(1, 16'hF001);
    send(0, 16'hF002);
    send(0, 16'hF003);
    wclr(7'h03);
    send(0, 16'hF004);
    wcmd(3'b000);
    wcmd(3'b110);
    wcmd(3'b010);
    step(); step();
    // random mix
    for (int i = 0; i < 4000; i++) begin
      msg_valid = ($urandom_range(0, 2) != 0);
      msg_sev = 2'($urandom_range(0, 3));
      msg_src = 16'($urandom);
      cmd_we = ($urandom_range(0, 7) == 0);
      cmd_wdata = 3'($urandom);
      sts_clr_we = ($urandom_range(0, 5) == 0);
      sts_clr_mask = 7'($urandom);
      vec_we = ($urandom_range(0, 15) == 0);
      vec_wdata = 5'($urandom);
      if ($urandom_range(0, 63) == 0) msi_mode = ~msi_mode;
      step();
    end
    step();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule